// File: doc/BRIEF.md
# Parallel Flash Bus Master

This block lets a synchronous host issue reads and writes to an asynchronous NOR-style parallel flash. A request carries an address, a direction, write data and a burst length. The block then drives chip enable, output enable, write enable, the address lines and the data-bus drivers for the number of system clock cycles set on its timing inputs. Read data comes back one beat at a time, each beat marked by a single-cycle valid strobe.

Reads can be a single random access or a page burst of up to eight beats. In a burst, the first beat pays the full random-access latency. Each later beat changes only the address and waits the shorter in-page latency, unless its address opens a new page. In that case that beat pays the random latency again. A write is a single strobe, sequenced so that the address and data are settled before write enable falls and stay held until after it rises. A mode input selects 16-bit word addressing or 8-bit byte addressing.

Top module: `pflash_master`

## Requirements
- R1: After reset, chip enable, output enable and write enable are high, the data drivers are off, rd_valid is low and req_ready is high.
- R2: A read holds chip enable and output enable low and write enable high with a fixed address for max(cfg_t_rand,1) cycles. It samples fl_dq_i at the end of the last of those cycles, and rd_valid pulses for one cycle in the next cycle with that data.
- R3: req_len gives the number of beats minus one (0 means 1 beat, 7 means 8 beats). Beat k reads address req_addr+k. Each beat after the first that stays inside the page holds its address for max(cfg_t_page,1) cycles. Data is returned in address order.
- R4: A burst beat whose address starts a new page holds its address for max(cfg_t_rand,1) cycles. A new page starts where the low 3 address bits are zero in word mode and where the low 4 bits are zero in byte mode.
- R5: When cfg_byte_mode is 1, rd_data bits 15..8 are zero and bits 7..0 come from fl_dq_i[7:0]. A write drives req_wdata[7:0] on fl_dq_o[7:0] with bits 15..8 zero.
- R6: A write holds output enable high throughout. It drives chip enable low with the address and data for max(cfg_t_edge,1) cycles before write enable falls. Write enable then stays low for max(cfg_t_wep,1) cycles, and chip enable, address and data are held for max(cfg_t_edge,1) cycles after write enable rises.
- R7: The data drivers are on throughout every cycle in which write enable is low and in the cycle after it, and the driven value does not change in those cycles. The drivers are off whenever output enable is low or chip enable is high.
- R8: req_ready is low while chip enable is low. Every bus cycle starts after at least one cycle with all three enables high, including a read that follows a write.
- R9: A write produces exactly one write-enable pulse, whatever req_len holds.
- R10: A timing input of zero acts as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_byte_mode | input | 1 | 1 = 8-bit byte addressing, 0 = 16-bit word addressing |
| cfg_t_rand | input | 8 | Random-access latency in cycles |
| cfg_t_page | input | 8 | In-page access latency in cycles |
| cfg_t_wep | input | 8 | Write-enable low width in cycles |
| cfg_t_edge | input | 8 | Setup and hold cycles around the write pulse |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Start address (word or byte unit) |
| req_len | input | 3 | Read beats minus one |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 16 | Read data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | 24 | Flash address |
| fl_dq_o | output | 16 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Enable for the data drivers |
| fl_dq_i | input | 16 | Data read from the flash |

## Verification
The last data strobe of a read and the acceptance of the next request fall in the same cycle. That cycle is also the all-high gap that separates bus cycles. The bench provokes this by holding a write request valid while a single read is still in flight. It then judges three things: the read strobe in that cycle carries the right data, ready is high with every enable high, and the write that follows still meets its setup, pulse and hold counts. A flash model that returns poison data until the required latency has elapsed makes any shortened access show up as wrong data.

// File: rtl/pflash_pkg.sv
// Package: shared state encoding and page geometry for the flash bus master.
// Assumes a page of 2**PG_BITS words (twice that many bytes in byte mode).
package pflash_pkg;
    localparam int PG_BITS = 3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WSET  = 3'd2,
        ST_WPUL  = 3'd3,
        ST_WHLD  = 3'd4
    } pf_state_e;
endpackage

// File: rtl/pflash_timer.sv
// Module: down-counter that times one bus phase.
// A load of N gives max(N,1) cycles until done; a load of 0 behaves as 1.
module pflash_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Load the phase length minus one, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? '0 : load_val - ONE;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pflash_page_addr.sv
// Module: computes the next burst address and whether it opens a new page.
// Assumes word pages of 2**PG_BITS entries; byte pages use one extra bit.
module pflash_page_addr #(
    parameter int ADDR_W  = 24,
    parameter int PG_BITS = 3
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              byte_mode,
    output logic [ADDR_W-1:0] next_addr,
    output logic              new_page
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    // Increment and look at the in-page bits of the result.
    always_comb begin
        next_addr = cur_addr + ONE;
        if (byte_mode) begin
            new_page = (next_addr[PG_BITS:0] == '0);
        end else begin
            new_page = (next_addr[PG_BITS-1:0] == '0);
        end
    end
endmodule

// File: rtl/pflash_seq.sv
// Module: bus-cycle sequencer. Accepts one request in idle, then walks
// read beats or the write setup/pulse/hold phases using an external timer.
// Assumes the timer reports done in the cycle its programmed phase ends.
module pflash_seq
    import pflash_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 16,
    parameter int CNT_W   = 8,
    parameter int LEN_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  t_rand,
    input  logic [CNT_W-1:0]  t_page,
    input  logic [CNT_W-1:0]  t_wep,
    input  logic [CNT_W-1:0]  t_edge,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] wdata_fmt,
    output logic              req_ready,
    input  logic              tmr_done,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    input  logic [ADDR_W-1:0] nxt_addr,
    input  logic              nxt_new_page,
    output logic [ADDR_W-1:0] addr_q,
    output logic              sample,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe
);
    localparam logic [LEN_W-1:0] ONE_L = {{(LEN_W-1){1'b0}}, 1'b1};

    pf_state_e         state_q;
    logic [LEN_W-1:0]  left_q;
    logic [DATA_W-1:0] wdata_q;
    logic              accept;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;

    // Phase transitions, address stepping and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    addr_q  <= req_addr;
                    wdata_q <= wdata_fmt;
                    left_q  <= req_len;
                    state_q <= req_write ? ST_WSET : ST_READ;
                end
                ST_READ: if (tmr_done) begin
                    if (left_q == '0) begin
                        state_q <= ST_IDLE;
                    end else begin
                        left_q <= left_q - ONE_L;
                        addr_q <= nxt_addr;
                    end
                end
                ST_WSET: if (tmr_done) state_q <= ST_WPUL;
                ST_WPUL: if (tmr_done) state_q <= ST_WHLD;
                ST_WHLD: if (tmr_done) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Pick the length of the phase about to begin.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = t_rand;
        case (state_q)
            ST_IDLE: begin
                tmr_load = accept;
                tmr_val  = req_write ? t_edge : t_rand;
            end
            ST_READ: begin
                tmr_load = tmr_done && (left_q != '0);
                tmr_val  = nxt_new_page ? t_rand : t_page;
            end
            ST_WSET: begin
                tmr_load = tmr_done;
                tmr_val  = t_wep;
            end
            ST_WPUL: begin
                tmr_load = tmr_done;
                tmr_val  = t_edge;
            end
            default: begin
                tmr_load = 1'b0;
                tmr_val  = t_rand;
            end
        endcase
    end

    // Bus pin decode from the phase register.
    always_comb begin
        ce_n   = (state_q == ST_IDLE);
        oe_n   = (state_q != ST_READ);
        we_n   = (state_q != ST_WPUL);
        dq_oe  = (state_q == ST_WSET) || (state_q == ST_WPUL) || (state_q == ST_WHLD);
        dq_o   = wdata_q;
        sample = (state_q == ST_READ) && tmr_done;
    end
endmodule

// File: rtl/pflash_master.sv
// Module: top of the parallel flash bus master. Joins the sequencer, the
// phase timer and the page address stepper, and formats byte-lane data.
// Assumes the configuration inputs are held steady while a cycle runs.
module pflash_master
    import pflash_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_byte_mode,
    input  logic [CNT_W-1:0]  cfg_t_rand,
    input  logic [CNT_W-1:0]  cfg_t_page,
    input  logic [CNT_W-1:0]  cfg_t_wep,
    input  logic [CNT_W-1:0]  cfg_t_edge,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [PG_BITS-1:0] req_len,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_dq_o,
    output logic              fl_dq_oe,
    input  logic [DATA_W-1:0] fl_dq_i
);
    localparam int LOW_W = 8;

    logic              tmr_load, tmr_done, sample, nxt_new_page;
    logic [CNT_W-1:0]  tmr_val;
    logic [ADDR_W-1:0] nxt_addr;
    logic [DATA_W-1:0] wdata_fmt, rdata_fmt;

    // Byte mode uses only the low lane in both directions.
    generate
        if (DATA_W > LOW_W) begin : g_lanes
            assign wdata_fmt = cfg_byte_mode ? {{(DATA_W-LOW_W){1'b0}}, req_wdata[LOW_W-1:0]} : req_wdata;
            assign rdata_fmt = cfg_byte_mode ? {{(DATA_W-LOW_W){1'b0}}, fl_dq_i[LOW_W-1:0]} : fl_dq_i;
        end else begin : g_narrow
            assign wdata_fmt = req_wdata;
            assign rdata_fmt = fl_dq_i;
        end
    endgenerate

    pflash_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    pflash_page_addr #(.ADDR_W(ADDR_W), .PG_BITS(PG_BITS)) u_pga (
        .cur_addr  (fl_addr),
        .byte_mode (cfg_byte_mode),
        .next_addr (nxt_addr),
        .new_page  (nxt_new_page)
    );

    pflash_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .LEN_W(PG_BITS)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .t_rand       (cfg_t_rand),
        .t_page       (cfg_t_page),
        .t_wep        (cfg_t_wep),
        .t_edge       (cfg_t_edge),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_len      (req_len),
        .wdata_fmt    (wdata_fmt),
        .req_ready    (req_ready),
        .tmr_done     (tmr_done),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .nxt_addr     (nxt_addr),
        .nxt_new_page (nxt_new_page),
        .addr_q       (fl_addr),
        .sample       (sample),
        .ce_n         (fl_ce_n),
        .oe_n         (fl_oe_n),
        .we_n         (fl_we_n),
        .dq_o         (fl_dq_o),
        .dq_oe        (fl_dq_oe)
    );

    // Register each sampled beat and raise its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= sample;
            if (sample) rd_data <= rdata_fmt;
        end
    end
endmodule

// File: rtl/pflash_master_chk.sv
// Module: protocol checker for the flash bus master, bound to its top.
// Assumes synchronous active-low reset; all properties are off in reset.
module pflash_master_chk #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              fl_ce_n,
    input logic              fl_oe_n,
    input logic              fl_we_n,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [DATA_W-1:0] fl_dq_o,
    input logic              fl_dq_oe
);
    // R2: a read keeps write enable high inside an enabled cycle.
    p_read_we_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (fl_we_n && !fl_ce_n));

    // R6: the write strobe only falls inside chip enable, output enable high.
    p_write_oe_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (fl_oe_n && !fl_ce_n));

    // R6: address and data already settled when write enable falls.
    p_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_o) && !$past(fl_ce_n)));

    // R7: data driven and unchanged during the pulse and the cycle after it.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |=> (fl_dq_oe && $stable(fl_dq_o) && $stable(fl_addr)));

    // R7: no drive while the flash may drive or is deselected.
    p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_oe_n || fl_ce_n) |-> !fl_dq_oe);

    // R8: no request accepted while a bus cycle is open.
    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_ce_n |-> !req_ready);

    // R8: every bus cycle is preceded by an all-high cycle.
    p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_ce_n) |-> ($past(fl_oe_n) && $past(fl_we_n)));
endmodule

bind pflash_master pflash_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .fl_ce_n   (fl_ce_n),
    .fl_oe_n   (fl_oe_n),
    .fl_we_n   (fl_we_n),
    .fl_addr   (fl_addr),
    .fl_dq_o   (fl_dq_o),
    .fl_dq_oe  (fl_dq_oe)
);

// File: tb/pflash_master_test.sv
// Bench: directed scenarios against a latency-enforcing flash model.
module pflash_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_byte_mode = 1'b0;
    logic [7:0]  cfg_t_rand = 8'd8, cfg_t_page = 8'd3, cfg_t_wep = 8'd4, cfg_t_edge = 8'd1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready, rd_valid;
    logic [23:0] req_addr = '0;
    logic [2:0]  req_len = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rd_data;
    logic        fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
    logic [23:0] fl_addr;
    logic [15:0] fl_dq_o, fl_dq_i;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pflash_master uut (
        .clk(clk), .rst_n(rst_n), .cfg_byte_mode(cfg_byte_mode),
        .cfg_t_rand(cfg_t_rand), .cfg_t_page(cfg_t_page), .cfg_t_wep(cfg_t_wep),
        .cfg_t_edge(cfg_t_edge), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
        .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i)
    );

    function automatic int eff(input logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    function automatic logic [15:0] patt(input logic [23:0] a);
        return a[15:0] ^ 16'hA5C3;
    endfunction

    // Flash model: poison data until the needed latency has passed.
    logic [23:0] m_last, m_open, m_pg;
    logic        m_low_prev = 1'b0, m_open_v = 1'b0;
    int          m_age = 0, m_cur, m_need;
    wire         m_low = !fl_ce_n && !fl_oe_n;
    always_comb begin
        m_pg   = cfg_byte_mode ? (fl_addr >> 4) : (fl_addr >> 3);
        m_cur  = (m_low && m_low_prev && fl_addr == m_last) ? m_age : 0;
        m_need = (m_open_v && m_pg == m_open) ? eff(cfg_t_page) : eff(cfg_t_rand);
        fl_dq_i = (m_low && m_cur + 1 >= m_need) ? patt(fl_addr) : 16'hBAD0;
    end
    always @(posedge clk) begin
        m_last     <= fl_addr;
        m_low_prev <= m_low;
        m_age      <= m_cur + 1;
        if (!m_low) m_open_v <= 1'b0;
        else if (m_cur + 1 >= m_need) begin
            m_open_v <= 1'b1;
            m_open   <= m_pg;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive a request at a falling edge and wait for its acceptance edge.
    task automatic issue(input bit wr, input logic [23:0] a, input logic [2:0] len,
                         input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_len = len; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
    endtask

    // Watch a read after acceptance; verify beat timing, data and stalling.
    task automatic watch_read(input logic [23:0] a, input int beats, input string req);
        int exp_n[8];
        int cum = 0, got = 0;
        bit rdy_bad = 0;
        for (int k = 0; k < beats; k++) begin
            logic [23:0] ak = a + 24'(k);
            bit np = cfg_byte_mode ? (ak[3:0] == 4'd0) : (ak[2:0] == 3'd0);
            cum += (k == 0 || np) ? eff(cfg_t_rand) : eff(cfg_t_page);
            exp_n[k] = cum + 1;
        end
        for (int n = 1; n < 200 && got < beats; n++) begin
            @(negedge clk);
            if (n == 1) req_valid = 1'b0;
            if (!fl_ce_n && req_ready) rdy_bad = 1;
            if (rd_valid) begin
                logic [23:0] ak = a + 24'(got);
                logic [15:0] e = cfg_byte_mode ? {8'h00, patt(ak)[7:0]} : patt(ak);
                chk(n == exp_n[got], req, "beat cycle", 32'(n), 32'(exp_n[got]));
                chk(rd_data == e, req, "beat data", 32'(rd_data), 32'(e));
                got++;
            end
        end
        chk(got == beats, req, "beat count", 32'(got), 32'(beats));
        chk(!rdy_bad, "R8", "ready low during read", 32'(rdy_bad), 0);
        @(negedge clk);
        chk(!rd_valid && fl_ce_n, req, "no extra beat", 32'(rd_valid), 0);
    endtask

    // Watch a write after acceptance; verify phases, values and drive.
    task automatic watch_write(input logic [23:0] a, input logic [15:0] d);
        int su = 0, pw = 0, hd = 0, pulses = 0;
        bit seen = 0, oe_bad = 0, drv_bad = 0, val_bad = 0, rdy_bad = 0, prev_we = 1;
        logic [15:0] ed = cfg_byte_mode ? {8'h00, d[7:0]} : d;
        for (int n = 1; n < 80; n++) begin
            @(negedge clk);
            if (n == 1) req_valid = 1'b0;
            if (!fl_ce_n) begin
                seen = 1;
                if (!fl_oe_n) oe_bad = 1;
                if (!fl_dq_oe) drv_bad = 1;
                if (req_ready) rdy_bad = 1;
                if (fl_addr != a || fl_dq_o != ed) val_bad = 1;
                if (fl_we_n) begin
                    if (pw == 0) su++; else hd++;
                end else begin
                    pw++;
                    if (prev_we) pulses++;
                end
                prev_we = fl_we_n;
            end else if (seen) break;
        end
        chk(su == eff(cfg_t_edge), "R6", "setup cycles", 32'(su), 32'(eff(cfg_t_edge)));
        chk(pw == eff(cfg_t_wep), "R6", "pulse cycles", 32'(pw), 32'(eff(cfg_t_wep)));
        chk(hd == eff(cfg_t_edge), "R6", "hold cycles", 32'(hd), 32'(eff(cfg_t_edge)));
        chk(!oe_bad, "R6", "oe high in write", 32'(oe_bad), 0);
        chk(!val_bad, "R6", "address/data on bus", 32'(fl_dq_o), 32'(ed));
        chk(!drv_bad, "R7", "drivers on in write", 32'(drv_bad), 0);
        chk(!rdy_bad, "R8", "ready low in write", 32'(rdy_bad), 0);
        chk(pulses == 1, "R9", "write pulses", 32'(pulses), 1);
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            chk(fl_ce_n && fl_we_n && !fl_dq_oe, "R9", "bus quiet after write",
                32'({fl_ce_n, fl_we_n, fl_dq_oe}), 32'(3'b110));
        end
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        chk(fl_ce_n && fl_oe_n && fl_we_n, "R1", "enables high",
            32'({fl_ce_n, fl_oe_n, fl_we_n}), 32'(3'b111));
        chk(!fl_dq_oe && !rd_valid && req_ready, "R1", "drive/valid/ready",
            32'({fl_dq_oe, rd_valid, req_ready}), 32'(3'b001));
    endtask

    task automatic t_random_read;
        cfg_byte_mode = 0; cfg_t_rand = 8; cfg_t_page = 3;
        issue(0, 24'h000123, 3'd0, 16'h0); watch_read(24'h000123, 1, "R2");
        cfg_t_rand = 5;
        issue(0, 24'h00ABCD, 3'd0, 16'h0); watch_read(24'h00ABCD, 1, "R2");
        cfg_t_rand = 8;
    endtask

    task automatic t_page_burst;
        issue(0, 24'h000200, 3'd7, 16'h0); watch_read(24'h000200, 8, "R3");
        issue(0, 24'h000311, 3'd2, 16'h0); watch_read(24'h000311, 3, "R3");
    endtask

    task automatic t_page_cross;
        issue(0, 24'h000105, 3'd4, 16'h0); watch_read(24'h000105, 5, "R4");
    endtask

    task automatic t_byte_mode;
        cfg_byte_mode = 1;
        issue(0, 24'h000036, 3'd3, 16'h0); watch_read(24'h000036, 4, "R5");
        issue(0, 24'h00003E, 3'd3, 16'h0); watch_read(24'h00003E, 4, "R4");
        issue(1, 24'h000041, 3'd0, 16'hBEEF); watch_write(24'h000041, 16'hBEEF);
        cfg_byte_mode = 0;
    endtask

    task automatic t_write;
        issue(1, 24'h005555, 3'd5, 16'h00AA); watch_write(24'h005555, 16'h00AA);
        cfg_t_edge = 3; cfg_t_wep = 6;
        issue(1, 24'h002AAA, 3'd0, 16'h1234); watch_write(24'h002AAA, 16'h1234);
        cfg_t_edge = 1; cfg_t_wep = 4;
    endtask

    task automatic t_zero_counts;
        cfg_t_rand = 0; cfg_t_page = 0; cfg_t_wep = 0; cfg_t_edge = 0;
        issue(0, 24'h000406, 3'd3, 16'h0); watch_read(24'h000406, 4, "R10");
        issue(1, 24'h000777, 3'd0, 16'h4321); watch_write(24'h000777, 16'h4321);
        cfg_t_rand = 8; cfg_t_page = 3; cfg_t_wep = 4; cfg_t_edge = 1;
    endtask

    // Read strobe and next acceptance fall in the same all-high cycle.
    task automatic t_back_to_back;
        int vn = 0, an = 0;
        logic [15:0] vd = '0;
        issue(0, 24'h000830, 3'd0, 16'h0);
        for (int n = 1; n < 40 && an == 0; n++) begin
            @(negedge clk);
            if (n == 1) begin
                req_valid = 1; req_write = 1; req_addr = 24'h000831; req_wdata = 16'h5A5A;
            end
            if (rd_valid) begin vn = n; vd = rd_data; end
            if (req_ready) begin
                an = n;
                chk(fl_ce_n && fl_oe_n && fl_we_n, "R8", "idle gap at hand-over",
                    32'({fl_ce_n, fl_oe_n, fl_we_n}), 32'(3'b111));
            end
        end
        chk(vn == 9 && an == 9, "R8", "strobe and accept cycle", 32'(vn), 32'(an));
        chk(vd == patt(24'h000830), "R2", "hand-over read data", 32'(vd), 32'(patt(24'h000830)));
        @(posedge clk);
        watch_write(24'h000831, 16'h5A5A);
        issue(0, 24'h000832, 3'd0, 16'h0); watch_read(24'h000832, 1, "R8");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset_state();
        t_random_read();
        t_page_burst();
        t_page_cross();
        t_byte_mode();
        t_write();
        t_zero_counts();
        t_back_to_back();
        repeat (4) @(posedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule